// File: doc/BRIEF.md
# Antenna Driver Segment Modulation Controller

This block sets the state of every output segment of two push-pull antenna drivers. Each driver is built from a row of segments with binary-weighted output resistance. The strongest segment sits at the top index. A carrier-phase input sets the toggling rhythm. A transmit-enable input and a modulation-active input, together with a set of configuration inputs, decide which segments toggle, which are held, and which float.

The unmodulated level is the set of segments selected by the normal-level mask. AM modulation narrows that set to a second mask, which raises the driver impedance. OOK modulation either freezes every segment in the state it had just before modulation began, or floats them all when the OOK-tristate option is set. In single-driver mode one driver floats, and an output-select input chooses which driver keeps the carrier.

A phase boundary is a clock cycle in which `car_ph` differs from the value registered in the previous cycle. The controller is a five-state machine whose states are OFF, CARRIER, AM, OOK_HOLD and OOK_HIZ. The state and all segment outputs change only at a phase boundary. At each boundary the next state is chosen in priority order:
- transmit disabled: OFF
- otherwise, modulation inactive: CARRIER
- otherwise, AM selected: AM
- otherwise, tristate option set: OOK_HIZ
- otherwise: OOK_HOLD

Any state can move to any other state at a boundary. Between boundaries the machine stays where it is.

Top module: `rf_seg_mod_ctrl`

## Requirements
- R1: During reset and after it, until the first phase boundary, every segment of both drivers floats: `drv_hz` is all ones and `drv_hi`/`drv_lo` are all zeros. Segment s of driver d sits at flattened bit d*SEG_W+s.
- R2: At a boundary with `tx_en`=0, every segment of both drivers floats.
- R3: In CARRIER, segment s of driver 0 is driven (`drv_hz` bit 0) when bit s of `norm_mask` is 1. A driven segment has hi = `car_ph` and lo = ~`car_ph`. Driver 1 is driven in antiphase, with hi = ~`car_ph` and lo = `car_ph`. Segments whose mask bit is 0 float.
- R4: No segment ever has hi and lo high together, and a floating segment has hi = lo = 0.
- R5: In AM (`mod_am`=1), `am_mask` replaces `norm_mask` as the set of driven segments. Phase and antiphase follow the same rules as R3.
- R6: In OOK_HOLD (`mod_am`=0, `ook_hiz`=0), every output holds the value it had at the boundary before entry, while `car_ph` keeps toggling.
- R7: In OOK_HIZ (`mod_am`=0, `ook_hiz`=1), every segment of both drivers floats.
- R8: With `single_mode`=1, outside OOK_HOLD, the driver whose index differs from `out_sel` floats entirely. `out_sel`=0 keeps driver 0 and `out_sel`=1 keeps driver 1.
- R9: Between phase boundaries the outputs do not change, even when the masks or mode inputs change.
- R10: A change of `car_ph` driven before clock edge k appears on the outputs after edge k, one register stage later. Mask and mode inputs take effect as sampled at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, faster than the carrier phase rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| car_ph | input | 1 | Carrier phase; each change is a phase boundary |
| tx_en | input | 1 | Transmitter enable |
| mod_act | input | 1 | Modulation interval active |
| mod_am | input | 1 | Modulation type: 1 = AM, 0 = OOK |
| ook_hiz | input | 1 | Float all segments during OOK instead of holding them |
| single_mode | input | 1 | Use one driver only |
| out_sel | input | 1 | Driver kept in single mode |
| norm_mask | input | SEG_W | Segments driven at the unmodulated level (all ones expected after reset) |
| am_mask | input | SEG_W | Segments driven during AM modulation |
| drv_hi | output | 2*SEG_W | High-side enable per segment |
| drv_lo | output | 2*SEG_W | Low-side enable per segment |
| drv_hz | output | 2*SEG_W | Float control per segment |

## Verification
The properties assume that `car_ph` changes at most once per clock and stays stable around the clock edge. They also assume that mode inputs present at a boundary are the ones meant for the phase that starts there. The stimulus changes every input only on the falling clock edge. It toggles `car_ph` at most once per several clocks, and it changes masks and modes between boundaries on purpose, to check that such changes wait for the next boundary. While an OOK hold is in progress, the bench keeps `single_mode` and `out_sel` unchanged.

// File: rtl/rf_seg_pkg.sv
package rf_seg_pkg;
    typedef enum logic [2:0] {
        ST_OFF      = 3'd0,
        ST_CARRIER  = 3'd1,
        ST_AM       = 3'd2,
        ST_OOK_HOLD = 3'd3,
        ST_OOK_HIZ  = 3'd4
    } seg_state_e;

    localparam int unsigned NUM_DRV = 2;
endpackage

// File: rtl/rf_seg_edge.sv
module rf_seg_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic car_ph,
    output logic boundary
);
    logic ph_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= 1'b0;
        else        ph_q <= car_ph;
    end

    assign boundary = car_ph ^ ph_q;
endmodule

// File: rtl/rf_seg_fsm.sv
module rf_seg_fsm
    import rf_seg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       boundary,
    input  logic       tx_en,
    input  logic       mod_act,
    input  logic       mod_am,
    input  logic       ook_hiz,
    output seg_state_e state_nxt
);
    seg_state_e state_q;
    seg_state_e request;

    // request decoded in priority order
    always_comb begin
        if (!tx_en)        request = ST_OFF;
        else if (!mod_act) request = ST_CARRIER;
        else if (mod_am)   request = ST_AM;
        else if (ook_hiz)  request = ST_OOK_HIZ;
        else               request = ST_OOK_HOLD;
    end

    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_OFF, ST_CARRIER, ST_AM, ST_OOK_HOLD, ST_OOK_HIZ:
                if (boundary) state_nxt = request;
            default: state_nxt = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_nxt;
    end
endmodule

// File: rtl/rf_seg_drv.sv
module rf_seg_drv
    import rf_seg_pkg::*;
#(
    parameter int unsigned SEG_W   = 8,
    parameter int unsigned DRV_IDX = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             boundary,
    input  seg_state_e       state_nxt,
    input  logic             car_ph,
    input  logic [SEG_W-1:0] norm_mask,
    input  logic [SEG_W-1:0] am_mask,
    input  logic             single_mode,
    input  logic             out_sel,
    output logic [SEG_W-1:0] hi,
    output logic [SEG_W-1:0] lo,
    output logic [SEG_W-1:0] hz
);
    localparam bit INV = (DRV_IDX % 2) == 1;
    localparam bit SEL = (DRV_IDX % 2) == 1;

    logic             pol;
    logic             active;
    logic [SEG_W-1:0] en;
    logic [SEG_W-1:0] hi_d, lo_d, hz_d;
    logic             hold;

    assign pol    = INV ? ~car_ph : car_ph;
    assign active = ~single_mode | (out_sel == SEL);

    always_comb begin
        en   = '0;
        hold = 1'b0;
        unique case (state_nxt)
            ST_OFF:      en = '0;
            ST_CARRIER:  en = norm_mask;
            ST_AM:       en = am_mask;
            ST_OOK_HOLD: hold = 1'b1;
            ST_OOK_HIZ:  en = '0;
            default:     en = '0;
        endcase
        if (!active) en = '0;
        hi_d = en & {SEG_W{pol}};
        lo_d = en & {SEG_W{~pol}};
        hz_d = ~en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi <= '0;
            lo <= '0;
            hz <= '1;
        end else if (boundary && !hold) begin
            hi <= hi_d;
            lo <= lo_d;
            hz <= hz_d;
        end
    end
endmodule

// File: rtl/rf_seg_mod_ctrl.sv
module rf_seg_mod_ctrl
    import rf_seg_pkg::*;
#(
    parameter int unsigned SEG_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     car_ph,
    input  logic                     tx_en,
    input  logic                     mod_act,
    input  logic                     mod_am,
    input  logic                     ook_hiz,
    input  logic                     single_mode,
    input  logic                     out_sel,
    input  logic [SEG_W-1:0]         norm_mask,
    input  logic [SEG_W-1:0]         am_mask,
    output logic [NUM_DRV*SEG_W-1:0] drv_hi,
    output logic [NUM_DRV*SEG_W-1:0] drv_lo,
    output logic [NUM_DRV*SEG_W-1:0] drv_hz
);
    logic       boundary;
    seg_state_e state_nxt;

    rf_seg_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .car_ph   (car_ph),
        .boundary (boundary)
    );

    rf_seg_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .boundary  (boundary),
        .tx_en     (tx_en),
        .mod_act   (mod_act),
        .mod_am    (mod_am),
        .ook_hiz   (ook_hiz),
        .state_nxt (state_nxt)
    );

    for (genvar d = 0; d < NUM_DRV; d++) begin : g_drv
        rf_seg_drv #(.SEG_W(SEG_W), .DRV_IDX(d)) u_drv (
            .clk         (clk),
            .rst_n       (rst_n),
            .boundary    (boundary),
            .state_nxt   (state_nxt),
            .car_ph      (car_ph),
            .norm_mask   (norm_mask),
            .am_mask     (am_mask),
            .single_mode (single_mode),
            .out_sel     (out_sel),
            .hi          (drv_hi[d*SEG_W +: SEG_W]),
            .lo          (drv_lo[d*SEG_W +: SEG_W]),
            .hz          (drv_hz[d*SEG_W +: SEG_W])
        );
    end
endmodule

// File: rtl/rf_seg_chk.sv
module rf_seg_chk #(
    parameter int unsigned SEG_W = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 car_ph,
    input logic                 tx_en,
    input logic                 mod_act,
    input logic                 mod_am,
    input logic                 ook_hiz,
    input logic                 single_mode,
    input logic                 out_sel,
    input logic [2*SEG_W-1:0]   drv_hi,
    input logic [2*SEG_W-1:0]   drv_lo,
    input logic [2*SEG_W-1:0]   drv_hz
);
    logic prev_ph;
    logic bnd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_ph <= 1'b0;
        else        prev_ph <= car_ph;
    end
    assign bnd = car_ph ^ prev_ph;

    // R4
    no_shoot_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((drv_hi & drv_lo) == '0) && (((drv_hi | drv_lo) & drv_hz) == '0));

    // R9
    hold_between_edges_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bnd |=> ($stable(drv_hi) && $stable(drv_lo) && $stable(drv_hz)));

    // R2
    tx_off_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bnd && !tx_en) |=> (drv_hz == '1));

    // R7
    ook_hiz_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bnd && tx_en && mod_act && !mod_am && ook_hiz) |=> (drv_hz == '1));

    // R6
    ook_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bnd && tx_en && mod_act && !mod_am && !ook_hiz) |=>
            ($stable(drv_hi) && $stable(drv_lo) && $stable(drv_hz)));

    // R8
    single_idle_drv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bnd && single_mode && !(tx_en && mod_act && !mod_am && !ook_hiz)) |=>
            (out_sel ? (drv_hz[SEG_W-1:0] == '1) : (drv_hz[2*SEG_W-1:SEG_W] == '1)));
endmodule

bind rf_seg_mod_ctrl rf_seg_chk #(.SEG_W(SEG_W)) u_chk (.*);

// File: tb/test_rf_seg_mod_ctrl.sv
module test_rf_seg_mod_ctrl;
    localparam int SEG_W = 8;
    localparam int VW    = 2 * SEG_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic car_ph = 1'b0, tx_en = 1'b0, mod_act = 1'b0, mod_am = 1'b0;
    logic ook_hiz = 1'b0, single_mode = 1'b0, out_sel = 1'b0;
    logic [SEG_W-1:0] norm_mask = '1, am_mask = '0;
    logic [VW-1:0] drv_hi, drv_lo, drv_hz;
    logic [VW-1:0] m_hi, m_lo, m_hz;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    rf_seg_mod_ctrl #(.SEG_W(SEG_W)) i_rf_seg_mod_ctrl (
        .clk(clk), .rst_n(rst_n), .car_ph(car_ph), .tx_en(tx_en),
        .mod_act(mod_act), .mod_am(mod_am), .ook_hiz(ook_hiz),
        .single_mode(single_mode), .out_sel(out_sel),
        .norm_mask(norm_mask), .am_mask(am_mask),
        .drv_hi(drv_hi), .drv_lo(drv_lo), .drv_hz(drv_hz)
    );

    task automatic check(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        check({req, " hi"}, drv_hi, m_hi);
        check({req, " lo"}, drv_lo, m_lo);
        check({req, " hz"}, drv_hz, m_hz);
    endtask

    // expected outputs at a boundary, taken from the requirements
    task automatic model_step();
        logic [SEG_W-1:0] en;
        if (tx_en && mod_act && !mod_am && !ook_hiz) return; // R6 hold
        for (int d = 0; d < 2; d++) begin
            logic p;
            if (!tx_en || (mod_act && !mod_am)) en = '0;
            else if (mod_act) en = am_mask;
            else en = norm_mask;
            if (single_mode && (out_sel != d[0])) en = '0;
            p = (d == 1) ? ~car_ph : car_ph;
            m_hi[d*SEG_W +: SEG_W] = en & {SEG_W{p}};
            m_lo[d*SEG_W +: SEG_W] = en & {SEG_W{~p}};
            m_hz[d*SEG_W +: SEG_W] = ~en;
        end
    endtask

    task automatic phase_step(input string req);
        @(negedge clk);
        car_ph = ~car_ph;
        model_step();
        @(posedge clk);
        @(negedge clk);
        check_all(req);
    endtask

    task automatic t_reset();
        m_hi = '0; m_lo = '0; m_hz = '1;
        @(negedge clk);
        check_all("R1 in reset");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check_all("R1 after reset");
    endtask

    task automatic t_carrier();
        @(negedge clk); tx_en = 1'b1; norm_mask = '1;
        phase_step("R3 full mask ph1");
        phase_step("R3 full mask ph0");
        @(negedge clk); norm_mask = 8'b1010_0110;
        phase_step("R3 partial mask");
        phase_step("R3 partial mask other phase");
    endtask

    task automatic t_latency();
        logic [VW-1:0] old_hi;
        @(negedge clk);
        old_hi = drv_hi;
        car_ph = ~car_ph;
        model_step();
        #1;
        check("R10 before edge", drv_hi, old_hi);
        @(posedge clk); @(negedge clk);
        check_all("R10 one edge later");
    endtask

    task automatic t_am();
        @(negedge clk); am_mask = 8'b0000_1111; mod_am = 1'b1; mod_act = 1'b1;
        phase_step("R5 am mask");
        phase_step("R5 am mask other phase");
        @(negedge clk); mod_act = 1'b0;
        phase_step("R3 back to normal");
    endtask

    task automatic t_ook_hold();
        @(negedge clk); norm_mask = '1;
        phase_step("R3 before hold");
        @(negedge clk); mod_am = 1'b0; ook_hiz = 1'b0; mod_act = 1'b1;
        phase_step("R6 hold entry");
        phase_step("R6 hold second phase");
        phase_step("R6 hold third phase");
        @(negedge clk); mod_act = 1'b0;
        phase_step("R3 after hold");
    endtask

    task automatic t_ook_hiz();
        @(negedge clk); ook_hiz = 1'b1; mod_act = 1'b1;
        phase_step("R7 tristate");
        phase_step("R7 tristate second phase");
        @(negedge clk); mod_act = 1'b0; ook_hiz = 1'b0;
        phase_step("R3 after tristate");
    endtask

    task automatic t_single();
        @(negedge clk); single_mode = 1'b1; out_sel = 1'b0;
        phase_step("R8 keep driver 0");
        @(negedge clk); out_sel = 1'b1;
        phase_step("R8 keep driver 1");
        @(negedge clk); mod_am = 1'b1; mod_act = 1'b1; am_mask = 8'b1100_0011;
        phase_step("R8 single with AM");
        @(negedge clk); mod_act = 1'b0; mod_am = 1'b0; single_mode = 1'b0;
        phase_step("R3 dual again");
    endtask

    task automatic t_boundary_only();
        logic [VW-1:0] h, l, z;
        h = drv_hi; l = drv_lo; z = drv_hz;
        @(negedge clk); norm_mask = 8'b0000_0001; single_mode = 1'b1; tx_en = 1'b0;
        repeat (4) @(negedge clk);
        check("R9 hi stable", drv_hi, h);
        check("R9 lo stable", drv_lo, l);
        check("R9 hz stable", drv_hz, z);
        @(negedge clk); tx_en = 1'b1;
        phase_step("R9 new config at boundary");
    endtask

    task automatic t_tx_off();
        @(negedge clk); tx_en = 1'b0;
        phase_step("R2 tx off");
        phase_step("R2 tx off second phase");
    endtask

    initial begin
        t_reset();
        t_carrier();
        t_latency();
        t_am();
        t_ook_hold();
        t_ook_hiz();
        t_single();
        t_boundary_only();
        t_tx_off();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1ms;
        checks++;
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule